// File: doc/BRIEF.md
# Dual-Byte Serial Frame Shifter

This block puts a 16-bit binary word onto a single asynchronous serial line as two back-to-back characters. Each character is framed as 8N1: one low start bit, eight data bits sent least significant bit first, and one high stop bit. When the strobe is accepted, the controller builds both characters, framing bits included, into one 20-bit shift register in a single step. It then shifts that register out one bit per bit period. A busy flag covers the whole transfer. The bit period comes from a clock divider whose ratio is set by the system clock and baud rate parameters. At the defaults of 50 MHz and 19200 baud, this is 2604 cycles, or about 52 µs per bit. An error of a few percent is acceptable to a receiver.

The controller has three states. `ST_IDLE` holds the line high and waits for a strobe. `ST_SEND` shifts out bits 0 to 18 of the frame. `ST_LAST` holds the final stop bit for its full period. The transitions are:

- **accept**: `ST_IDLE` to `ST_SEND`, on a strobe while idle.
- **penultimate**: `ST_SEND` to `ST_LAST`, on the bit tick that leaves bit 18.
- **release**: `ST_LAST` to `ST_IDLE`, on the tick that ends the final stop bit.

A parameter picks which byte of the word goes out first.

Top module: `dual_byte_tx`

## Requirements
- R1: During and directly after reset, `tx_o` is 1 and `busy_o` is 0.
- R2: Whenever `busy_o` is 0, `tx_o` is 1 (idle-high line).
- R3: A `load_i` high while idle is accepted at that clock edge. In the next cycle `busy_o` is 1 and `tx_o` is 0, which is the first start bit.
- R4: The 20 serial bits are, in order: 0, the first byte's bits 0 to 7, 1, 0, the second byte's bits 0 to 7, 1. There is no idle gap between the first stop bit and the second start bit.
- R5: With `HI_FIRST`=1 (the default), `word_i[15:8]` is the first byte and `word_i[7:0]` the second. With `HI_FIRST`=0 the order is reversed.
- R6: Every serial bit, including framing bits, lasts exactly CLK_HZ/BAUD clock cycles.
- R7: A `load_i` strobe while `busy_o` is 1 has no effect. The bits being sent do not change, and no further word follows.
- R8: `busy_o` stays 1 until the final stop bit has lasted its full period. It falls exactly 20 bit periods after the accepting edge, and `tx_o` then remains 1.
- R9: A new word can be accepted in the first cycle in which `busy_o` is 0 again, giving back-to-back words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_i | input | 16 | Word to send, sampled on the accepting edge |
| load_i | input | 1 | Start strobe, honoured only while idle |
| tx_o | output | 1 | Serial transmit line, high when idle |
| busy_o | output | 1 | High from acceptance until the last stop bit ends |

## Verification
On every cycle, the bound checker enforces four properties. The line is high whenever the block is idle. An accepted strobe produces a start bit in the next cycle. Bit ticks are spaced exactly one divider period apart. The line only moves on a tick, which also covers strobes ignored while busy. The checker also requires that busy drops only on a tick. The bench alone can show that the bits carry the right data in the right byte order, because that needs the word that was loaded. The same holds for the exact release time of busy, for the absence of a second word after an ignored strobe, and for back-to-back acceptance.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_LAST = 2'd2
    } tx_state_e;

    // serial bits per character: start + data + stop
    function automatic int slot_bits(input int char_w);
        return char_w + 2;
    endfunction

endpackage

// File: rtl/dbtx_bit_timer.sv
module dbtx_bit_timer #(
    parameter int DIV = 2604
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= RELOAD;
        end else if (restart_i) begin
            cnt_q <= RELOAD;
        end else if (run_i) begin
            cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
        end
    end

    assign tick_o = run_i && !restart_i && (cnt_q == '0);

endmodule

// File: rtl/dbtx_frame_pack.sv
module dbtx_frame_pack #(
    parameter int CHAR_W   = 8,
    parameter int CHARS    = 2,
    parameter bit HI_FIRST = 1'b1
) (
    input  logic [CHAR_W*CHARS-1:0]     word_i,
    output logic [CHARS*(CHAR_W+2)-1:0] frame_o
);
    localparam int SLOT_W = dbtx_pkg::slot_bits(CHAR_W);

    for (genvar c = 0; c < CHARS; c++) begin : g_slot
        localparam int SRC = HI_FIRST ? (CHARS - 1 - c) : c;
        assign frame_o[c*SLOT_W]                  = 1'b0;
        assign frame_o[c*SLOT_W+1 +: CHAR_W]      = word_i[SRC*CHAR_W +: CHAR_W];
        assign frame_o[c*SLOT_W+CHAR_W+1]         = 1'b1;
    end

endmodule

// File: rtl/dbtx_shift_ctrl.sv
module dbtx_shift_ctrl
    import dbtx_pkg::*;
#(
    parameter int FRAME_W = 20
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               tick_i,
    output logic               tx_o,
    output logic               busy_o,
    output logic               restart_o,
    output logic               run_o
);
    localparam int IDX_W = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] PEN_IDX = IDX_W'(FRAME_W - 2);

    tx_state_e          state_q, state_d;
    logic [FRAME_W-1:0] sreg_q;
    logic [IDX_W-1:0]   idx_q;
    logic               accept;

    assign accept = (state_q == ST_IDLE) && load_i;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // transitions: accept, penultimate, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i)                      state_d = ST_SEND;
            ST_SEND: if (tick_i && idx_q == PEN_IDX)  state_d = ST_LAST;
            ST_LAST: if (tick_i)                      state_d = ST_IDLE;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    // shift register and bit index
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sreg_q <= '1;
            idx_q  <= '0;
        end else if (accept) begin
            sreg_q <= frame_i;
            idx_q  <= '0;
        end else if (state_q != ST_IDLE && tick_i) begin
            sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
            if (state_q == ST_SEND) idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        tx_o      = sreg_q[0];
        busy_o    = (state_q != ST_IDLE);
        run_o     = (state_q != ST_IDLE);
        restart_o = accept;
    end

endmodule

// File: rtl/dual_byte_tx.sv
module dual_byte_tx #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int BAUD     = 19_200,
    parameter bit HI_FIRST = 1'b1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [15:0] word_i,
    input  logic        load_i,
    output logic        tx_o,
    output logic        busy_o
);
    localparam int CHAR_W  = 8;
    localparam int CHARS   = 2;
    localparam int DIV     = CLK_HZ / BAUD;
    localparam int FRAME_W = CHARS * dbtx_pkg::slot_bits(CHAR_W);

    logic [FRAME_W-1:0] frame;
    logic               bit_tick;
    logic               restart;
    logic               run;

    dbtx_frame_pack #(
        .CHAR_W  (CHAR_W),
        .CHARS   (CHARS),
        .HI_FIRST(HI_FIRST)
    ) u_pack (
        .word_i (word_i),
        .frame_o(frame)
    );

    dbtx_bit_timer #(
        .DIV(DIV)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(restart),
        .run_i    (run),
        .tick_o   (bit_tick)
    );

    dbtx_shift_ctrl #(
        .FRAME_W(FRAME_W)
    ) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load_i),
        .frame_i  (frame),
        .tick_i   (bit_tick),
        .tx_o     (tx_o),
        .busy_o   (busy_o),
        .restart_o(restart),
        .run_o    (run)
    );

endmodule

// File: rtl/dual_byte_tx_chk.sv
module dual_byte_tx_chk #(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 19_200
) (
    input logic clk,
    input logic rst_n,
    input logic load,
    input logic busy,
    input logic tx,
    input logic tick
);
    localparam int DIV   = CLK_HZ / BAUD;
    localparam int GAP_W = $clog2(DIV + 1);

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (load && !busy)    gap_q <= '0;
        else if (tick)             gap_q <= '0;
        else if (busy)             gap_q <= gap_q + 1'b1;
    end

    a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    a_r3_start_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> (busy && !tx));

    a_r6_bit_period: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == GAP_W'(DIV - 1)));

    a_r7_line_moves_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(tx));

    a_r8_busy_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));

endmodule

bind dual_byte_tx dual_byte_tx_chk #(
    .CLK_HZ(CLK_HZ),
    .BAUD  (BAUD)
) u_chk (
    .clk  (clk_i),
    .rst_n(rst_ni),
    .load (load_i),
    .busy (busy_o),
    .tx   (tx_o),
    .tick (bit_tick)
);

// File: tb/dual_byte_tx_tb.sv
module dual_byte_tx_tb;
    localparam int CLK_HZ = 50_000_000;
    localparam int BAUD   = 5_000_000;
    localparam int DIV    = CLK_HZ / BAUD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data = '0;
    logic        start = 1'b0;
    logic        tx_hi, busy_hi, tx_lo, busy_lo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_byte_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .HI_FIRST(1'b1)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .word_i(data), .load_i(start),
        .tx_o(tx_hi), .busy_o(busy_hi));

    dual_byte_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .HI_FIRST(1'b0)) u_dut_lo (
        .clk_i(clk), .rst_ni(rst_n), .word_i(data), .load_i(start),
        .tx_o(tx_lo), .busy_o(busy_lo));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected serial bit k of a 20-bit transfer (R4, R5)
    function automatic logic exp_bit(input logic [15:0] w, input int k, input bit hi_first);
        int slot = k / 10;
        int pos  = k % 10;
        logic [7:0] b;
        b = ((slot == 0) == hi_first) ? w[15:8] : w[7:0];
        if (pos == 0) return 1'b0;
        if (pos == 9) return 1'b1;
        return b[pos-1];
    endfunction

    task automatic send_word(input logic [15:0] w, input bit inject);
        data  = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3 busy after accept", {busy_hi, busy_lo}, 2'b11);
        chk("R3 start bit", {tx_hi, tx_lo}, 2'b00);
        for (int k = 0; k < 20; k++) begin
            if (k == 0) begin
                repeat (DIV/2) @(negedge clk);
            end else if (inject && k == 5) begin
                @(negedge clk);
                start = 1'b1;
                data  = ~w;
                @(negedge clk);
                start = 1'b0;
                repeat (DIV-2) @(negedge clk);
            end else begin
                repeat (DIV) @(negedge clk);
            end
            chk(inject ? "R7 R4 R6 bit hi-first" : "R4 R5 R6 bit hi-first",
                tx_hi, exp_bit(w, k, 1'b1));
            chk(inject ? "R7 R5 bit lo-first" : "R5 R6 bit lo-first",
                tx_lo, exp_bit(w, k, 1'b0));
            chk("R8 busy during word", {busy_hi, busy_lo}, 2'b11);
        end
        repeat (DIV/2 - 1) @(negedge clk);
        chk("R8 busy through last stop", {busy_hi, busy_lo, tx_hi, tx_lo}, 4'b1111);
        @(negedge clk);
        chk("R8 busy released", {busy_hi, busy_lo, tx_hi, tx_lo}, 4'b0011);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {tx_hi, busy_hi, tx_lo, busy_lo}, 4'b1010);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {tx_hi, busy_hi, tx_lo, busy_lo}, 4'b1010);
        repeat (5) @(negedge clk);
        chk("R2 idle high", {tx_hi, busy_hi, tx_lo, busy_lo}, 4'b1010);

        // directed corners
        send_word(16'h0000, 1'b0);
        send_word(16'hFFFF, 1'b0);   // R9 back-to-back
        send_word(16'hA55A, 1'b0);
        send_word(16'h0180, 1'b1);   // R7 strobe while busy
        repeat (3*DIV) @(negedge clk);
        chk("R7 no extra word", {tx_hi, busy_hi, tx_lo, busy_lo}, 4'b1010);

        // random words, some with ignored strobes, some back-to-back (R9)
        for (int i = 0; i < 16; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            send_word(w, ($urandom % 3) == 0);
            if ($urandom % 2) repeat (1 + $urandom % 7) @(negedge clk);
        end

        repeat (2*DIV) @(negedge clk);
        chk("R2 idle high at end", {tx_hi, busy_hi, tx_lo, busy_lo}, 4'b1010);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule